// File: doc/BRIEF.md
# One-Wire Bus Master Slot Timer

This block produces the bit-level waveforms of a single-wire bus master. It pulls an open-drain data line low by raising an output-enable pin and otherwise leaves the line to its pull-up resistor. One command starts one operation: a bus reset with presence detection, a write-0 slot, a write-1 slot or a read slot. Each operation runs at standard or overdrive speed. When the operation ends, the block pulses `done` and presents the result bit. All durations are whole multiples of a clock-ticks-per-microsecond parameter.

The controller has five states. `ST_IDLE` waits for a command. `ST_STRETCH` holds the line released before a reset that needs a longer recovery than the one already given. `ST_LOW` drives the line low. `ST_HIGH` releases the line for the rest of the slot and samples it. `ST_RECOVER` keeps the line released for the recovery gap.

The transitions are:
- IDLE→LOW: a command is accepted.
- IDLE→STRETCH: a reset arrives before its recovery gap has elapsed.
- STRETCH→LOW: the gap is complete.
- LOW→HIGH: the low time has expired.
- HIGH→RECOVER: the slot ends, and `done` pulses.
- RECOVER→IDLE: recovery is complete.

A read slot drives the same low pulse as a write-1 slot and then samples the line. Recovery time is added after the slot and does not count as part of it.

Top module: `owm_slot_timer`

## Requirements
- R1: After reset, `bus_oe`, `busy`, `done` and `rx_bit` are all 0.
- R2: A write-1 slot drives `bus_oe` for STD_LOW1_US µs at standard speed and for OD_LOW1_US µs at overdrive. This time is capped so that the read sample falls no later than (15 µs or 2 µs) minus RISE_TICKS. It must also stay at least 5 µs (standard) or 1 µs (overdrive).
- R3: A read slot (cmd_op=2'b11) drives the same low pulse as a write-1 slot (cmd_op=2'b10). The line is sampled READ_SAMP_TICKS after release, and `rx_bit` equals the sampled level.
- R4: A write-0 slot (cmd_op=2'b01) holds the line low for 60 µs (standard) or 7 µs (overdrive). Every slot lasts 65 µs (standard) or 8 µs (overdrive) from its first low cycle up to and including the `done` cycle.
- R5: A reset (cmd_op=2'b00) holds the line low for RST_LOW_STD_US or RST_LOW_OD_US µs, then releases it for 410 µs or 40 µs. Presence is sampled 70 µs or 9 µs after release, and `rx_bit`=1 means the line was low at that sample.
- R6: `done` is a one-cycle pulse in the last slot cycle. After it, `busy` stays high for exactly the recovery time: 5 µs at standard speed, 2 µs at overdrive, and 1 µs at overdrive when HIGH_SUPPLY=1.
- R7: A command presented while `busy` is high is ignored. It starts no low pulse, and the running slot keeps its own timing.
- R8: The released time between the end of a slot and the low edge of a following reset is at least 5 µs for a reset of 640 µs or less and at least 10 µs for a longer reset. When the preceding recovery is shorter, the block stretches the wait to exactly that value.
- R9: The line is only ever pulled low, through `bus_oe`. Each operation produces exactly one contiguous low run, and that run lies inside `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, accepted only while not busy |
| cmd_op | input | 2 | 00 reset, 01 write-0, 10 write-1, 11 read |
| cmd_od | input | 1 | 1 selects overdrive speed |
| bus_in | input | 1 | Sampled level of the data line |
| bus_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Operation or recovery in progress |
| done | output | 1 | One-cycle end-of-slot strobe |
| rx_bit | output | 1 | Read level or presence flag of the last sampling operation |

## Verification
Every command code is run at both speeds, and each run measures the low-pulse length, the slot length and the recovery length. These measurements separate the per-operation and per-speed duration tables. Reads and resets are run with a simulated device holding the line high and then low, which shows that the sample is taken from the line and not from a constant. Back-to-back pairs check recovery: overdrive followed by a standard reset, overdrive followed by overdrive on a high-supply instance, and standard followed by a long reset. These pairs tell the plain recovery apart from the stretched pre-reset gap. A command held high through a whole slot shows that input arriving during busy is rejected.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_WRITE0 = 2'b01,
        OP_WRITE1 = 2'b10,
        OP_READ   = 2'b11
    } owm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRETCH,
        ST_LOW,
        ST_HIGH,
        ST_RECOVER
    } owm_state_e;
endpackage

// File: rtl/owm_slot_durations.sv
module owm_slot_durations
    import owm_pkg::*;
#(
    parameter int TICKS_PER_US    = 8,
    parameter int STD_LOW1_US     = 6,
    parameter int OD_LOW1_US      = 1,
    parameter int READ_SAMP_TICKS = 2,
    parameter int RISE_TICKS      = 2,
    parameter int HIGH_SUPPLY     = 0,
    parameter int RST_LOW_STD_US  = 480,
    parameter int RST_LOW_OD_US   = 70,
    parameter int STD_SLOT_US     = 65,
    parameter int OD_SLOT_US      = 8,
    parameter int STD_W0_US       = 60,
    parameter int OD_W0_US        = 7,
    parameter int STD_RST_HI_US   = 410,
    parameter int OD_RST_HI_US    = 40,
    parameter int STD_PRES_US     = 70,
    parameter int OD_PRES_US      = 9,
    parameter int CNT_W           = 14
) (
    input  owm_op_e          op,
    input  logic             od,
    output logic [CNT_W-1:0] low_t,
    output logic [CNT_W-1:0] high_t,
    output logic [CNT_W-1:0] samp_t,
    output logic             samp_en,
    output logic [CNT_W-1:0] rec_t,
    output logic [CNT_W-1:0] pre_rst_t
);
    localparam int T = TICKS_PER_US;
    // write-1 / read low time, capped so the sample lands inside the window
    localparam int STD_W1_CAP = 15 * T - RISE_TICKS - READ_SAMP_TICKS;
    localparam int OD_W1_CAP  = 2 * T - RISE_TICKS - READ_SAMP_TICKS;
    localparam int STD_W1_T   = (STD_LOW1_US * T > STD_W1_CAP) ? STD_W1_CAP : STD_LOW1_US * T;
    localparam int OD_W1_T    = (OD_LOW1_US * T > OD_W1_CAP) ? OD_W1_CAP : OD_LOW1_US * T;
    localparam int STD_SLOT_T = STD_SLOT_US * T;
    localparam int OD_SLOT_T  = OD_SLOT_US * T;
    localparam int STD_W0_T   = STD_W0_US * T;
    localparam int OD_W0_T    = OD_W0_US * T;
    localparam int STD_PRE_T  = (RST_LOW_STD_US > 640) ? 10 * T : 5 * T;
    localparam int OD_PRE_T   = (RST_LOW_OD_US > 640) ? 10 * T : 5 * T;
    localparam int STD_REC_T  = 5 * T;

    logic [CNT_W-1:0] od_rec;

    generate
        if (HIGH_SUPPLY != 0) begin : g_rec_high_supply
            assign od_rec = CNT_W'(1 * T);
        end else begin : g_rec_normal
            assign od_rec = CNT_W'(2 * T);
        end
    endgenerate

    always_comb begin
        samp_en   = 1'b0;
        samp_t    = CNT_W'(READ_SAMP_TICKS);
        rec_t     = od ? od_rec : CNT_W'(STD_REC_T);
        pre_rst_t = od ? CNT_W'(OD_PRE_T) : CNT_W'(STD_PRE_T);
        unique case (op)
            OP_RESET: begin
                low_t   = od ? CNT_W'(RST_LOW_OD_US * T) : CNT_W'(RST_LOW_STD_US * T);
                high_t  = od ? CNT_W'(OD_RST_HI_US * T)  : CNT_W'(STD_RST_HI_US * T);
                samp_t  = od ? CNT_W'(OD_PRES_US * T)    : CNT_W'(STD_PRES_US * T);
                samp_en = 1'b1;
            end
            OP_WRITE0: begin
                low_t  = od ? CNT_W'(OD_W0_T) : CNT_W'(STD_W0_T);
                high_t = od ? CNT_W'(OD_SLOT_T - OD_W0_T) : CNT_W'(STD_SLOT_T - STD_W0_T);
            end
            OP_WRITE1: begin
                low_t  = od ? CNT_W'(OD_W1_T) : CNT_W'(STD_W1_T);
                high_t = od ? CNT_W'(OD_SLOT_T - OD_W1_T) : CNT_W'(STD_SLOT_T - STD_W1_T);
            end
            OP_READ: begin
                low_t   = od ? CNT_W'(OD_W1_T) : CNT_W'(STD_W1_T);
                high_t  = od ? CNT_W'(OD_SLOT_T - OD_W1_T) : CNT_W'(STD_SLOT_T - STD_W1_T);
                samp_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/owm_idle_tracker.sv
module owm_idle_tracker #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    // released-line cycles since the last slot, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '1;
        end else if (clear) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer
    import owm_pkg::*;
#(
    parameter int TICKS_PER_US    = 8,
    parameter int STD_LOW1_US     = 6,
    parameter int OD_LOW1_US      = 1,
    parameter int READ_SAMP_TICKS = 2,
    parameter int RISE_TICKS      = 2,
    parameter int HIGH_SUPPLY     = 0,
    parameter int RST_LOW_STD_US  = 480,
    parameter int RST_LOW_OD_US   = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_od,
    input  logic       bus_in,
    output logic       bus_oe,
    output logic       busy,
    output logic       done,
    output logic       rx_bit
);
    localparam int LONGEST = (RST_LOW_STD_US + 410 + 16) * TICKS_PER_US;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    owm_state_e       state, state_nx;
    owm_op_e          op_q, dur_op;
    logic             od_q, dur_od;
    logic [CNT_W-1:0] cnt, idle_cnt;
    logic [CNT_W-1:0] low_t, high_t, samp_t, rec_t, pre_rst_t;
    logic             samp_en, rx_q, accept;

    assign accept = (state == ST_IDLE) && cmd_valid;
    assign dur_op = (state == ST_IDLE) ? owm_op_e'(cmd_op) : op_q;
    assign dur_od = (state == ST_IDLE) ? cmd_od : od_q;

    owm_slot_durations #(
        .TICKS_PER_US   (TICKS_PER_US),
        .STD_LOW1_US    (STD_LOW1_US),
        .OD_LOW1_US     (OD_LOW1_US),
        .READ_SAMP_TICKS(READ_SAMP_TICKS),
        .RISE_TICKS     (RISE_TICKS),
        .HIGH_SUPPLY    (HIGH_SUPPLY),
        .RST_LOW_STD_US (RST_LOW_STD_US),
        .RST_LOW_OD_US  (RST_LOW_OD_US),
        .CNT_W          (CNT_W)
    ) u_dur (
        .op       (dur_op),
        .od       (dur_od),
        .low_t    (low_t),
        .high_t   (high_t),
        .samp_t   (samp_t),
        .samp_en  (samp_en),
        .rec_t    (rec_t),
        .pre_rst_t(pre_rst_t)
    );

    owm_idle_tracker #(.CNT_W(CNT_W)) u_idle (
        .clk  (clk),
        .rst_n(rst_n),
        .clear((state == ST_LOW) || (state == ST_HIGH)),
        .count(idle_cnt)
    );

    // state register and slot datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_RESET;
            od_q  <= 1'b0;
            cnt   <= '0;
            rx_q  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
            if (accept) begin
                op_q <= owm_op_e'(cmd_op);
                od_q <= cmd_od;
            end
            if (state == ST_HIGH && samp_en && cnt == samp_t - 1'b1) begin
                rx_q <= (op_q == OP_RESET) ? ~bus_in : bus_in;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (owm_op_e'(cmd_op) == OP_RESET && idle_cnt < pre_rst_t) state_nx = ST_STRETCH;
                    else                                                        state_nx = ST_LOW;
                end
            end
            ST_STRETCH: if (idle_cnt >= pre_rst_t - 1'b1) state_nx = ST_LOW;
            ST_LOW:     if (cnt == low_t - 1'b1)          state_nx = ST_HIGH;
            ST_HIGH:    if (cnt == high_t - 1'b1)         state_nx = ST_RECOVER;
            ST_RECOVER: if (idle_cnt >= rec_t - 1'b1)     state_nx = ST_IDLE;
            default:                                      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_oe = (state == ST_LOW);
        busy   = (state != ST_IDLE);
        done   = (state == ST_HIGH) && (cnt == high_t - 1'b1);
        rx_bit = rx_q;
    end
endmodule

// File: rtl/owm_slot_timer_chk.sv
module owm_slot_timer_chk #(
    parameter int TICKS_PER_US = 8,
    parameter int RISE_TICKS   = 2,
    parameter int CW           = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_oe,
    input logic       busy,
    input logic       done,
    input logic [1:0] op_q,
    input logic       od_q
);
    localparam int T = TICKS_PER_US;

    logic [CW-1:0] low_run, gap;
    logic          short_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
            gap     <= '1;
        end else begin
            low_run <= bus_oe ? low_run + 1'b1 : '0;
            if (bus_oe)        gap <= '0;
            else if (gap != '1) gap <= gap + 1'b1;
        end
    end

    assign short_slot = (op_q == 2'b10) || (op_q == 2'b11);

    p_low_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_oe) && short_slot) |-> (int'(low_run) >= (od_q ? T : 5 * T)));

    p_low_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_oe) && short_slot) |-> (int'(low_run) <= (od_q ? 2 * T : 15 * T) - RISE_TICKS));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_recover_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> busy);

    p_gap_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (int'(gap) >= T));

    p_oe_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> busy);

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_oe);
endmodule

bind owm_slot_timer owm_slot_timer_chk #(
    .TICKS_PER_US(TICKS_PER_US),
    .RISE_TICKS  (RISE_TICKS),
    .CW          (CNT_W + 1)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .bus_oe(bus_oe),
    .busy  (busy),
    .done  (done),
    .op_q  (op_q),
    .od_q  (od_q)
);

// File: tb/owm_slot_timer_tb.sv
module owm_slot_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic cmd_od = 1'b0;
    logic pull = 1'b0;
    logic sel = 1'b0;
    logic oe_a, busy_a, done_a, rx_a;
    logic oe_b, busy_b, done_b, rx_b;
    logic oe_m, busy_m, done_m, rx_m;
    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    owm_slot_timer #(.TICKS_PER_US(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid & ~sel), .cmd_op(cmd_op),
        .cmd_od(cmd_od), .bus_in(~(oe_a | pull)), .bus_oe(oe_a), .busy(busy_a),
        .done(done_a), .rx_bit(rx_a));

    owm_slot_timer #(.TICKS_PER_US(T), .HIGH_SUPPLY(1), .RST_LOW_STD_US(700)) u_dut_hs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid & sel), .cmd_op(cmd_op),
        .cmd_od(cmd_od), .bus_in(~(oe_b | pull)), .bus_oe(oe_b), .busy(busy_b),
        .done(done_b), .rx_bit(rx_b));

    assign oe_m   = sel ? oe_b   : oe_a;
    assign busy_m = sel ? busy_b : busy_a;
    assign done_m = sel ? done_b : done_a;
    assign rx_m   = sel ? rx_b   : rx_a;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge with the DUT idle; returns at the first idle negedge.
    task automatic slot(input logic [1:0] op, input logic od, output int low, output int runs,
                        output int pre, output int dur, output int rec, output int rx);
        int t;
        logic prev;
        low = 0; runs = 0; pre = -1; rec = 0; prev = 1'b0;
        cmd_op = op; cmd_od = od; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        t = 0;
        while (!done_m && t < 20000) begin
            if (oe_m) begin
                low++;
                if (!prev) runs++;
                if (pre < 0) pre = t;
            end
            prev = oe_m;
            t++;
            @(negedge clk);
        end
        dur = t + 1;
        rx = int'(rx_m);
        @(negedge clk);
        while (busy_m && rec < 20000) begin
            rec++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        chk("R1 bus_oe", int'(oe_a), 0);
        chk("R1 busy", int'(busy_a), 0);
        chk("R1 done", int'(done_a), 0);
        chk("R1 rx_bit", int'(rx_a), 0);
    endtask

    task automatic t_std_slots();
        int low, runs, pre, dur, rec, rx;
        slot(2'b10, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R2 std write1 low", low, 6 * T);
        chk("R4 std write1 slot", dur, 65 * T);
        chk("R6 std recovery", rec, 5 * T);
        chk("R9 std write1 runs", runs, 1);
        pull = 1'b0;
        slot(2'b11, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R3 std read low", low, 6 * T);
        chk("R3 std read released=1", rx, 1);
        pull = 1'b1;
        slot(2'b11, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R3 std read held=0", rx, 0);
        pull = 1'b0;
        slot(2'b01, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R4 std write0 low", low, 60 * T);
        chk("R4 std write0 slot", dur, 65 * T);
    endtask

    task automatic t_std_reset();
        int low, runs, pre, dur, rec, rx;
        pull = 1'b1;
        slot(2'b00, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R5 std reset low", low, 480 * T);
        chk("R5 std reset length", dur, 890 * T);
        chk("R5 presence seen", rx, 1);
        chk("R8 no stretch after std slot", pre, 0);
        pull = 1'b0;
        slot(2'b00, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R5 no presence", rx, 0);
        chk("R9 reset runs", runs, 1);
    endtask

    task automatic t_od_slots();
        int low, runs, pre, dur, rec, rx;
        slot(2'b10, 1'b1, low, runs, pre, dur, rec, rx);
        chk("R2 od write1 low", low, 1 * T);
        chk("R4 od write1 slot", dur, 8 * T);
        chk("R6 od recovery", rec, 2 * T);
        slot(2'b01, 1'b1, low, runs, pre, dur, rec, rx);
        chk("R4 od write0 low", low, 7 * T);
        chk("R4 od write0 slot", dur, 8 * T);
        pull = 1'b1;
        slot(2'b11, 1'b1, low, runs, pre, dur, rec, rx);
        chk("R3 od read low", low, 1 * T);
        chk("R3 od read held=0", rx, 0);
        slot(2'b00, 1'b1, low, runs, pre, dur, rec, rx);
        chk("R8 od reset stretch gap", rec + 0, 2 * T);
        chk("R8 gap before od reset", 2 * T + 1 + pre, 5 * T);
        chk("R5 od reset low", low, 70 * T);
        chk("R5 od reset length", dur - pre, 110 * T);
        chk("R5 od presence", rx, 1);
        pull = 1'b0;
    endtask

    task automatic t_hold_off();
        int low, runs, extra;
        logic prev;
        low = 0; runs = 0; extra = 0; prev = 1'b0;
        cmd_op = 2'b01; cmd_od = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'b10;
        while (busy_m) begin
            if (oe_m) begin
                low++;
                if (!prev) runs++;
            end
            prev = oe_m;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (oe_m || busy_m) extra++;
        end
        chk("R7 single low run", runs, 1);
        chk("R7 write0 timing kept", low, 60 * T);
        chk("R7 no late start", extra, 0);
    endtask

    task automatic t_high_supply();
        int low, runs, pre, dur, rec, rx;
        slot(2'b10, 1'b1, low, runs, pre, dur, rec, rx);
        chk("R6 high-supply od recovery", rec, 1 * T);
        slot(2'b10, 1'b1, low, runs, pre, dur, rec, rx);
        chk("R6 od back-to-back gap", pre, 0);
        slot(2'b10, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R6 std recovery hs", rec, 5 * T);
        pull = 1'b1;
        slot(2'b00, 1'b0, low, runs, pre, dur, rec, rx);
        chk("R8 gap before long reset", 5 * T + 1 + pre, 10 * T);
        chk("R5 long reset low", low, 700 * T);
        chk("R5 long reset presence", rx, 1);
        pull = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_std_slots();
        t_std_reset();
        t_od_slots();
        t_hold_off();
        sel = 1'b1;
        @(negedge clk);
        t_high_supply();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule